// File: doc/BRIEF.md
# Two-Step Memory Window Configuration Sequencer

This block sits beside the register file of a small signal-processing core and governs five memory access windows plus one configuration register. Software arms a window in three steps. It makes two accesses to the configuration register: the first carries an address half and the second carries a mode half. Then it makes one access to the window it wants to arm. That window access stores the full 32-bit configuration in a slot. Each window has one slot for reads and one for writes, so the direction of the arming access chooses the slot.

For every window access the block reports whether the slot for that window and direction holds a nonzero configuration. If it does, the access is a programmed transfer. If it does not, the access is a plain 16-bit register read or write. If a second configuration pair completes before the first has been used, the block gives a one-cycle warning. The block does not perform the external memory transfers. All outputs are combinational on the current access and reflect the state held before the next clock edge.

Top module: `mem_cfg_sequencer`

## Requirements
- R1: After reset, the configuration word is zero, no configuration is pending, all twelve slots are zero and every raw window register reads zero.
- R2: `acc_sel` = 5 selects the configuration register. A write to it while no address half is held loads bits 31:16 of `cfg_word`. A write while the address half is held loads bits 15:0.
- R3: A read of the configuration register advances the two-step sequence in the same way as a write and leaves `cfg_word` unchanged. The read returns bits 31:16 on the first step and bits 15:0 on the second.
- R4: The second access of a pair sets `cfg_pending` from the next cycle. The flag stays set until a window access (`acc_sel` 0 to 4) consumes it. After that access, both the pending flag and the address-held flag are clear.
- R5: A window access while a configuration is pending pulses `cfg_capture` and stores `cfg_word` in the slot for that window and direction. In the internal slot index, read slots are 0 to 4 and write slots are 6 to 10. `acc_slot` shows the stored word on that access and on every later access to the same window in the same direction.
- R6: Read and write slots are independent. Arming a window through a read does not change the behaviour of writes to that window, and arming through a write does not change reads.
- R7: `cfg_unused_warn` pulses, for one cycle, on the second access of a pair made while a configuration is still pending. The new pair replaces the configuration word, and `cfg_pending` stays set.
- R8: `acc_prog` is high on a window access exactly when the slot for that window and direction is nonzero. On the capturing access, the newly captured word decides. A captured zero word leaves the window unprogrammed.
- R9: An unprogrammed window write stores `acc_wdata` in that window's raw register, and an unprogrammed read returns it. A programmed write leaves the raw register unchanged, and a programmed read returns zero.
- R10: `acc_sel` values 6 and 7 and cycles with `acc_valid` low change no state, raise no pulse and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Target: 0 to 4 windows, 5 configuration register, 6 and 7 none |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the current read access |
| acc_prog | output | 1 | Current window access is a programmed transfer |
| acc_slot | output | 32 | Configuration in effect for the current window access |
| cfg_capture | output | 1 | Current window access consumes the pending configuration |
| cfg_unused_warn | output | 1 | A pair completes while an earlier one is still pending |
| cfg_pending | output | 1 | A completed configuration waits for a window access |
| cfg_word | output | 32 | Configuration register: address half high, mode half low |

## Verification
The assertions assume that at most one access is presented per cycle and that `acc_sel` stays within its three bits. They also assume that inputs settle before the clock edge and that reset is held for at least one edge. The bench changes inputs just after each rising edge and holds them for the whole cycle. Its random sequence covers all eight select codes. About one write in eight carries zero data, so captured zero configurations and raw writes of zero both occur. Directed sequences before the random phase cover back-to-back pairs, arming by read and arming through the configuration read path.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Slot layout: read slots first, write slots one stride further on.
  function automatic int unsigned slot_of(input int unsigned win,
                                          input logic is_wr,
                                          input int unsigned stride);
    return is_wr ? win + stride : win;
  endfunction

  // Half of the configuration word addressed by a sequence step.
  function automatic logic [15:0] half_of(input logic [31:0] word,
                                          input logic low_half);
    return low_half ? word[15:0] : word[31:16];
  endfunction

endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl #(
  parameter int DW = 16,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_acc,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          win_acc,
  output logic [CW-1:0] cfg_q,
  output logic          pending_q,
  output logic [DW-1:0] cfg_rdata,
  output logic          warn
);

  logic have_addr_q;
  logic pair_done;
  logic consume;

  assign pair_done = cfg_acc && have_addr_q;
  assign consume   = win_acc && pending_q;
  assign warn      = pair_done && pending_q;
  assign cfg_rdata = have_addr_q ? cfg_q[DW-1:0] : cfg_q[CW-1:DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      have_addr_q <= 1'b0;
      pending_q   <= 1'b0;
    end else if (cfg_acc) begin
      if (!have_addr_q) begin
        have_addr_q <= 1'b1;
        if (wr) cfg_q[CW-1:DW] <= wdata;
      end else begin
        have_addr_q <= 1'b0;
        pending_q   <= 1'b1;
        if (wr) cfg_q[DW-1:0] <= wdata;
      end
    end else if (consume) begin
      pending_q   <= 1'b0;
      have_addr_q <= 1'b0;
    end
  end

  a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !win_acc) |=> pending_q);
  a_r4_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && win_acc && !cfg_acc) |=> (!pending_q && !have_addr_q));
  a_r7_warn_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (pending_q && cfg_acc));
  a_r2_addr_half_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_acc && wr && !have_addr_q) |=> (cfg_q[CW-1:DW] == $past(wdata)));
  a_r3_read_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_acc && !wr) |=> $stable(cfg_q));

endmodule

// File: rtl/mcs_slots.sv
module mcs_slots #(
  parameter int DW   = 16,
  parameter int NWIN = 5,
  localparam int CW     = 2 * DW,
  localparam int STRIDE = NWIN + 1,
  localparam int NSLOT  = 2 * STRIDE,
  localparam int SELW   = $clog2(NWIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_acc,
  input  logic            wr,
  input  logic [SELW-1:0] sel,
  input  logic            pending,
  input  logic [CW-1:0]   cfg,
  output logic            capture,
  output logic            prog,
  output logic [CW-1:0]   slot_word
);
  import mcs_pkg::*;

  logic [CW-1:0] slot_q [NSLOT];
  int unsigned   idx;
  logic [CW-1:0] eff;

  assign capture = win_acc && pending;

  always_comb begin
    idx = slot_of(32'(sel), wr, STRIDE);
    if (idx >= NSLOT) idx = 0;
    eff = capture ? cfg : slot_q[idx];
  end

  assign prog      = win_acc && (eff != '0);
  assign slot_word = win_acc ? eff : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (capture) begin
      slot_q[idx] <= cfg;
    end
  end

  a_r5_capture_stored: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (slot_q[$past(idx)] == $past(cfg)));
  a_r8_prog_only_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> win_acc);
  a_r5_capture_only_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> win_acc);

endmodule

// File: rtl/mcs_raw.sv
module mcs_raw #(
  parameter int DW   = 16,
  parameter int NWIN = 5,
  localparam int SELW = $clog2(NWIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_acc,
  input  logic            wr,
  input  logic            prog,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] raw_q [NWIN];
  logic [SELW-1:0] sidx;
  logic            do_wr;

  assign sidx  = (32'(sel) < NWIN) ? sel : '0;
  assign do_wr = win_acc && wr && !prog;
  assign rdata = (win_acc && !prog) ? raw_q[sidx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) raw_q[i] <= '0;
    end else if (do_wr) begin
      raw_q[sidx] <= wdata;
    end
  end

  a_r9_prog_write_keeps_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && wr && prog) |=> (raw_q[$past(sidx)] == $past(raw_q[sidx])));
  a_r9_raw_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> (raw_q[$past(sidx)] == $past(wdata)));

endmodule

// File: rtl/mem_cfg_sequencer.sv
module mem_cfg_sequencer #(
  parameter int DW   = 16,
  parameter int NWIN = 5,
  localparam int CW   = 2 * DW,
  localparam int SELW = $clog2(NWIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_wr,
  input  logic [SELW-1:0] acc_sel,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   acc_rdata,
  output logic            acc_prog,
  output logic [CW-1:0]   acc_slot,
  output logic            cfg_capture,
  output logic            cfg_unused_warn,
  output logic            cfg_pending,
  output logic [CW-1:0]   cfg_word
);

  localparam logic [SELW-1:0] CFG_SEL = SELW'(NWIN);

  logic          win_acc;
  logic          cfg_acc;
  logic [DW-1:0] cfg_rdata;
  logic [DW-1:0] raw_rdata;

  assign win_acc = acc_valid && (32'(acc_sel) < NWIN);
  assign cfg_acc = acc_valid && (acc_sel == CFG_SEL);

  mcs_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_acc(cfg_acc), .wr(acc_wr),
    .wdata(acc_wdata), .win_acc(win_acc), .cfg_q(cfg_word),
    .pending_q(cfg_pending), .cfg_rdata(cfg_rdata), .warn(cfg_unused_warn)
  );

  mcs_slots #(.DW(DW), .NWIN(NWIN)) u_slots (
    .clk(clk), .rst_n(rst_n), .win_acc(win_acc), .wr(acc_wr),
    .sel(acc_sel), .pending(cfg_pending), .cfg(cfg_word),
    .capture(cfg_capture), .prog(acc_prog), .slot_word(acc_slot)
  );

  mcs_raw #(.DW(DW), .NWIN(NWIN)) u_raw (
    .clk(clk), .rst_n(rst_n), .win_acc(win_acc), .wr(acc_wr),
    .prog(acc_prog), .sel(acc_sel), .wdata(acc_wdata), .rdata(raw_rdata)
  );

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_wr) begin
      if (cfg_acc)      acc_rdata = cfg_rdata;
      else if (win_acc) acc_rdata = raw_rdata;
    end
  end

  a_r10_idle_no_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc && !cfg_acc) |-> (!cfg_capture && !cfg_unused_warn && !acc_prog));
  a_r10_idle_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc && !cfg_acc) |=> ($stable(cfg_word) && $stable(cfg_pending)));

endmodule

// File: tb/test_mem_cfg_sequencer.sv
module test_mem_cfg_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_wr = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        acc_prog, cfg_capture, cfg_unused_warn, cfg_pending;
  logic [31:0] acc_slot, cfg_word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_cfg_sequencer i_mem_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_prog(acc_prog), .acc_slot(acc_slot), .cfg_capture(cfg_capture),
    .cfg_unused_warn(cfg_unused_warn), .cfg_pending(cfg_pending),
    .cfg_word(cfg_word)
  );

  // Reference state
  logic [31:0] m_rd [5];
  logic [31:0] m_wr [5];
  logic [15:0] m_raw [5];
  logic [31:0] m_cfg;
  bit          m_have, m_pend;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_win(input logic v, input logic [2:0] s);
    return v && (s < 3'd5);
  endfunction

  // One access: drive, check combinational outputs mid-cycle, update model.
  task automatic step(input string tag, input logic v, input logic w,
                      input logic [2:0] s, input logic [15:0] d);
    logic [31:0] e_slot;
    bit e_cap, e_warn, e_prog, win, cfga;
    logic [15:0] e_rd;
    @(posedge clk); #1;
    acc_valid = v; acc_wr = w; acc_sel = s; acc_wdata = d;
    win  = is_win(v, s);
    cfga = v && (s == 3'd5);
    e_cap  = win && m_pend;
    e_warn = cfga && m_have && m_pend;
    e_slot = '0;
    if (win) e_slot = e_cap ? m_cfg : (w ? m_wr[s] : m_rd[s]);
    e_prog = win && (e_slot != 0);
    e_rd = '0;
    if (v && !w) begin
      if (cfga) e_rd = m_have ? m_cfg[15:0] : m_cfg[31:16];
      else if (win && !e_prog) e_rd = m_raw[s];
    end
    #9;
    chk(tag, "rdata", 32'(acc_rdata), 32'(e_rd));
    chk(tag, "prog", 32'(acc_prog), 32'(e_prog));
    chk(tag, "slot", acc_slot, e_slot);
    chk(tag, "capture", 32'(cfg_capture), 32'(e_cap));
    chk(tag, "warn", 32'(cfg_unused_warn), 32'(e_warn));
    chk(tag, "pending", 32'(cfg_pending), 32'(m_pend));
    chk(tag, "cfgword", cfg_word, m_cfg);
    // model update for the coming edge
    if (cfga) begin
      if (!m_have) begin
        m_have = 1; if (w) m_cfg[31:16] = d;
      end else begin
        m_have = 0; m_pend = 1; if (w) m_cfg[15:0] = d;
      end
    end else if (win) begin
      if (e_cap) begin
        if (w) m_wr[s] = m_cfg; else m_rd[s] = m_cfg;
        m_pend = 0; m_have = 0;
      end
      if (w && !e_prog) m_raw[s] = d;
    end
  endtask

  task automatic arm(input string tag, input logic [15:0] a, input logic [15:0] m);
    step(tag, 1, 1, 3'd5, a);
    step(tag, 1, 1, 3'd5, m);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_raw[i] = 0; end
    m_cfg = 0; m_have = 0; m_pend = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, every window unprogrammed and reading zero
    step("R1", 0, 0, 3'd0, 16'h0);
    for (int i = 0; i < 5; i++) begin
      step("R1", 1, 0, 3'(i), 16'h0);
      step("R1", 1, 1, 3'(i), 16'h0);
    end
    // R9: raw write then read back
    step("R9", 1, 1, 3'd2, 16'hBEEF);
    step("R9", 1, 0, 3'd2, 16'h0);
    // R2/R4: load pair, pending held across idle cycles
    arm("R2", 16'h1234, 16'h5678);
    step("R4", 0, 0, 3'd0, 16'h0);
    step("R10", 1, 1, 3'd6, 16'hFFFF);
    step("R10", 1, 0, 3'd7, 16'h0);
    // R5: consumed by write on window 2 -> write slot
    step("R5", 1, 1, 3'd2, 16'hAAAA);
    step("R5", 1, 1, 3'd2, 16'h5555);
    // R6: reads of window 2 still raw
    step("R6", 1, 0, 3'd2, 16'h0);
    // R3: configuration via reads keeps word, returns halves
    step("R3", 1, 0, 3'd5, 16'h0);
    step("R3", 1, 0, 3'd5, 16'h0);
    step("R8", 1, 0, 3'd4, 16'h0);
    step("R8", 1, 0, 3'd4, 16'h0);
    // R7: second pair while pending
    arm("R7", 16'h0001, 16'h0002);
    arm("R7", 16'h00AB, 16'h00CD);
    step("R7", 1, 0, 3'd0, 16'h0);
    // R8: captured zero leaves window unprogrammed
    arm("R8", 16'h0, 16'h0);
    step("R8", 1, 1, 3'd1, 16'h7777);
    step("R8", 1, 0, 3'd1, 16'h0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      d = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
      step("rand", ($urandom % 6) != 0, 1'($urandom), 3'($urandom), d);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule